// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Bus Controller

This block sits between a clocked host and an external asynchronous static RAM of 2048 bytes. The host issues one read or one write at a time. The controller turns each request into active-low chip-select, output-enable and write-strobe waveforms, and holds every phase for a whole number of clock cycles. Each count is the ceiling of a nanosecond parameter divided by the clock period. The controller drives an 11-bit address and a split tri-state data bus (output value, output enable, input value). A single-cycle pulse tells the host when a write has finished or when read data is ready.

Writes are terminated by the write strobe. The address is presented before the strobe falls and is held until chip select rises. Write data is driven only while the strobe is low and for one cycle after it rises, and the output enable stays off for the whole write. Reads keep chip select and output enable low for the access time. The data is registered on the edge where that count expires.

A power-fail input blocks new accesses. A request that arrives while it is high is consumed and answered with an error pulse, and no strobe moves. An access that is already running finishes normally.

Top module: `sramc_top`

## Requirements
- R1: After reset, chip select, output enable and write strobe are high, the data bus enable is low, the controller is ready, and the done, valid and error pulses are low.
- R2: On an accepted write, chip select goes low together with the latched address, and stays low for N_AS = max(1, ceil(T_AS_NS/period)) cycles before the write strobe falls. The address does not change while chip select is low.
- R3: The write strobe stays low for exactly N_WP = max(ceil(T_WP_NS/period), ceil(T_DW_NS/period), 1) cycles. It is never low while chip select is high.
- R4: The data bus enable is high from the cycle the write strobe falls through one cycle after it rises, N_WP+1 cycles in total, and carries the request's write data. Output enable stays high during the whole write.
- R5: The write-done pulse lasts one cycle and rises max(N_AS+N_WP+1+N_WR, N_WC) cycles after the accepting edge. N_WR = max(1, ceil(T_WR_NS/period)) and N_WC = ceil(T_WC_NS/period).
- R6: On a read, chip select and output enable stay low for N_ACC = max(ceil of the access, output-enable and read-cycle times over the period, 1) cycles. The input bus is registered on the edge that ends that window, and a one-cycle valid pulse is raised with the data.
- R7: The data bus enable is low whenever output enable is low, and it is already low in the cycle before output enable falls.
- R8: A request accepted while power-fail is high gives a one-cycle error pulse. Chip select stays high and the memory contents are not changed.
- R9: Raising power-fail during a write in progress does not cut the write short. It completes with the normal timing and the data is stored.
- R10: The ready output is high only while the controller is idle. A request is taken on a rising edge where both request-valid and ready are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Controller idle, request may be taken |
| pwr_fail | input | 1 | Power-fail lockout, blocks new accesses |
| rsp_done | output | 1 | One-cycle pulse: write finished |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_err | output | 1 | One-cycle pulse: request refused by lockout |
| rsp_rdata | output | DW | Registered read data |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_addr | output | AW | Memory address |
| sram_dq_o | output | DW | Data driven to the memory |
| sram_dq_oe | output | 1 | Tri-state enable for sram_dq_o |
| sram_dq_i | input | DW | Data read from the memory |

## Verification
The bench builds the controller with a 20 ns period and the fastest-grade pulse and access times, which gives a three-cycle write strobe and a four-cycle read window. The write cycle time is raised to 160 ns, so the cycle-time floor takes over from the strobe sum and stretches the recovery phase. This makes the max() term in the done timing observable. The bench's memory model returns a marker byte until the final cycle of the read window, so data captured too early is caught.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPUL,
    ST_WHLD,
    ST_WREC,
    ST_RACC
  } sramc_st_t;

  function automatic int ns2cyc(input int ns, input int per, input int floor_c);
    int c;
    c = (ns + per - 1) / per;
    return (c < floor_c) ? floor_c : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
  parameter int CNTW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [CNTW-1:0] val_i,
  output logic            zero_o
);

  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sramc_bus.sv
module sramc_bus #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          latch_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          cap_i,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o  <= '0;
      wdata_o <= '0;
      rdata_o <= '0;
    end else begin
      if (latch_i) begin
        addr_o  <= addr_i;
        wdata_o <= wdata_i;
      end
      if (cap_i) begin
        rdata_o <= dq_i;
      end
    end
  end

endmodule

// File: rtl/sramc_top.sv
module sramc_top
  import sramc_pkg::*;
#(
  parameter int AW            = 11,
  parameter int DW            = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_AS_NS       = 0,
  parameter int T_WP_NS       = 55,
  parameter int T_DW_NS       = 30,
  parameter int T_WR_NS       = 5,
  parameter int T_WC_NS       = 70,
  parameter int T_ACC_NS      = 70,
  parameter int T_OE_NS       = 35,
  parameter int T_RC_NS       = 70
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  input  logic          pwr_fail,
  output logic          rsp_done,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic          sram_ce_n,
  output logic          sram_oe_n,
  output logic          sram_we_n,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_i
);

  localparam int N_AS  = ns2cyc(T_AS_NS, CLK_PERIOD_NS, 1);
  localparam int N_WP  = imax(ns2cyc(T_WP_NS, CLK_PERIOD_NS, 1),
                              ns2cyc(T_DW_NS, CLK_PERIOD_NS, 1));
  localparam int N_WR  = ns2cyc(T_WR_NS, CLK_PERIOD_NS, 1);
  localparam int N_WC  = ns2cyc(T_WC_NS, CLK_PERIOD_NS, 1);
  localparam int N_REC = imax(N_WR, N_WC - N_AS - N_WP - 1);
  localparam int N_ACC = imax(imax(ns2cyc(T_ACC_NS, CLK_PERIOD_NS, 1),
                                   ns2cyc(T_OE_NS, CLK_PERIOD_NS, 1)),
                              ns2cyc(T_RC_NS, CLK_PERIOD_NS, 1));
  localparam int NMAX  = imax(imax(N_AS, N_WP), imax(N_REC, N_ACC));
  localparam int CNTW  = $clog2(NMAX + 1);

  sramc_st_t       state_q;
  logic            tmr_load;
  logic [CNTW-1:0] tmr_val;
  logic            tmr_zero;
  logic            take;
  logic            start;
  logic            cap;

  assign req_ready = (state_q == ST_IDLE);
  assign take      = req_ready && req_valid;
  assign start     = take && !pwr_fail;
  assign cap       = (state_q == ST_RACC) && tmr_zero;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: if (start) begin
        tmr_load = 1'b1;
        tmr_val  = req_write ? CNTW'(N_AS - 1) : CNTW'(N_ACC - 1);
      end
      ST_WSET: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = CNTW'(N_WP - 1);
      end
      ST_WHLD: begin
        tmr_load = 1'b1;
        tmr_val  = CNTW'(N_REC - 1);
      end
      default: ;
    endcase
  end

  sramc_timer #(.CNTW(CNTW)) timer_i (
    .clk    (clk),
    .rst    (rst),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  sramc_bus #(.AW(AW), .DW(DW)) bus_i (
    .clk     (clk),
    .rst     (rst),
    .latch_i (start),
    .addr_i  (req_addr),
    .wdata_i (req_wdata),
    .cap_i   (cap),
    .dq_i    (sram_dq_i),
    .addr_o  (sram_addr),
    .wdata_o (sram_dq_o),
    .rdata_o (rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      sram_ce_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_dq_oe <= 1'b0;
      rsp_done   <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
    end else begin
      rsp_done  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (take && pwr_fail) begin
            rsp_err <= 1'b1;
          end else if (start) begin
            sram_ce_n <= 1'b0;
            if (req_write) begin
              state_q <= ST_WSET;
            end else begin
              sram_oe_n <= 1'b0;
              state_q   <= ST_RACC;
            end
          end
        end
        ST_WSET: if (tmr_zero) begin
          sram_we_n  <= 1'b0;
          sram_dq_oe <= 1'b1;
          state_q    <= ST_WPUL;
        end
        ST_WPUL: if (tmr_zero) begin
          sram_we_n <= 1'b1;
          state_q   <= ST_WHLD;
        end
        ST_WHLD: begin
          sram_dq_oe <= 1'b0;
          sram_ce_n  <= 1'b1;
          state_q    <= ST_WREC;
        end
        ST_WREC: if (tmr_zero) begin
          rsp_done <= 1'b1;
          state_q  <= ST_IDLE;
        end
        ST_RACC: if (tmr_zero) begin
          rsp_valid <= 1'b1;
          sram_ce_n <= 1'b1;
          sram_oe_n <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> !sram_ce_n); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr)); // R2
  AST_NO_OE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!sram_we_n || sram_dq_oe) |-> sram_oe_n); // R4
  AST_DRIVE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> !sram_ce_n); // R4
  AST_BUS_FREE_BEFORE_OE: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_oe_n) |-> !$past(sram_dq_oe)); // R7
  AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> sram_ce_n); // R8
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R5
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (sram_ce_n && sram_we_n)); // R10

endmodule

// File: tb/sramc_top_tb_top.sv
module sramc_top_tb_top;

  localparam int AW    = 11;
  localparam int DW    = 8;
  localparam int PER   = 20;
  localparam int E_AS  = 1;
  localparam int E_WP  = (55 + PER - 1) / PER;
  localparam int E_ACC = (70 + PER - 1) / PER;
  localparam int E_WC  = (160 + PER - 1) / PER;
  localparam int E_WTOT = (E_AS + E_WP + 2 > E_WC) ? (E_AS + E_WP + 2) : E_WC;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready;
  logic          pwr_fail = 1'b0;
  logic          rsp_done, rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic          sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_dq_o;
  logic [DW-1:0] sram_dq_i;

  int checks = 0;
  int errors = 0;
  int clash  = 0;
  bit ended  = 0;

  logic [DW-1:0] mem [0:(1<<AW)-1];
  int   acc_cnt = 0;
  logic we_q = 1'b1;
  logic oe_q = 1'b1;
  logic drv_q = 1'b0;

  always #(PER/2) clk = ~clk;

  sramc_top #(.AW(AW), .DW(DW), .CLK_PERIOD_NS(PER), .T_WC_NS(160)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .pwr_fail(pwr_fail), .rsp_done(rsp_done), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .sram_ce_n(sram_ce_n),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_addr(sram_addr),
    .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

  // memory model: data valid only in the last cycle of the access window
  assign sram_dq_i = (!sram_ce_n && !sram_oe_n && acc_cnt >= E_ACC) ? mem[sram_addr] : 8'hEE;

  always @(negedge clk) begin
    if (!sram_ce_n && !sram_oe_n) acc_cnt <= acc_cnt + 1;
    else acc_cnt <= 0;
    if (!sram_ce_n && !we_q && sram_we_n && sram_dq_oe) mem[sram_addr] <= sram_dq_o;
    if (!rst && !sram_oe_n && (sram_dq_oe || (oe_q && drv_q))) clash <= clash + 1;
    we_q  <= sram_we_n;
    oe_q  <= sram_oe_n;
    drv_q <= sram_dq_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic test_reset();
    chk(sram_ce_n && sram_oe_n && sram_we_n, "R1 strobes", {sram_ce_n, sram_oe_n, sram_we_n}, 7);
    chk(!sram_dq_oe, "R1 bus enable", sram_dq_oe, 0);
    chk(req_ready, "R1 ready", req_ready, 1);
    chk(!rsp_done && !rsp_valid && !rsp_err, "R1 pulses", {rsp_done, rsp_valid, rsp_err}, 0);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit pf_mid);
    int n = 0, ce = 0, we = 0, oe = 0, drv = 0, setup = 0, badv = 0, achg = 0, busy = 0;
    bit seen_we = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_done && n < 100) begin
      n++;
      if (pf_mid && n == 2) pwr_fail = 1'b1;
      if (req_ready) busy++;
      if (!sram_ce_n) ce++;
      if (!sram_we_n) begin we++; seen_we = 1; end
      else if (!sram_ce_n && !seen_we) setup++;
      if (!sram_oe_n) oe++;
      if (sram_dq_oe) begin drv++; if (sram_dq_o != d) badv++; end
      if (!sram_ce_n && sram_addr != a) achg++;
      @(negedge clk);
    end
    chk(setup == E_AS, "R2 setup cycles", setup, E_AS);
    chk(achg == 0, "R2 address change", achg, 0);
    chk(ce == E_AS + E_WP + 1, "R2 select cycles", ce, E_AS + E_WP + 1);
    chk(we == E_WP, "R3 strobe width", we, E_WP);
    chk(drv == E_WP + 1, "R4 drive cycles", drv, E_WP + 1);
    chk(badv == 0, "R4 drive value", badv, 0);
    chk(oe == 0, "R4 output enable in write", oe, 0);
    chk(n == E_WTOT, pf_mid ? "R9 done timing" : "R5 done timing", n, E_WTOT);
    chk(busy == 0, "R10 ready while busy", busy, 0);
    @(negedge clk);
    chk(!rsp_done, "R5 done one cycle", rsp_done, 0);
    chk(req_ready, "R10 ready after done", req_ready, 1);
    pwr_fail = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    int n = 0, oe = 0, drv = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && n < 100) begin
      n++;
      if (!sram_oe_n && !sram_ce_n) oe++;
      if (sram_dq_oe) drv++;
      @(negedge clk);
    end
    chk(oe == E_ACC, "R6 read window", oe, E_ACC);
    chk(n == E_ACC, "R6 valid timing", n, E_ACC);
    chk(rsp_rdata == exp, tag, rsp_rdata, exp);
    chk(drv == 0, "R7 drive during read", drv, 0);
    @(negedge clk);
    chk(!rsp_valid, "R6 valid one cycle", rsp_valid, 0);
  endtask

  task automatic do_reject(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    pwr_fail = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_err, "R8 error pulse", rsp_err, 1);
    chk(sram_ce_n, "R8 no select", sram_ce_n, 1);
    @(negedge clk);
    chk(!rsp_err, "R8 error one cycle", rsp_err, 0);
    chk(sram_ce_n && sram_we_n, "R8 still idle", {sram_ce_n, sram_we_n}, 3);
    pwr_fail = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    do_write(11'h000, 8'h5A, 1'b0);
    do_write(11'h7FF, 8'hA5, 1'b0);
    do_write(11'h123, 8'h3C, 1'b0);
    do_read(11'h000, 8'h5A, "R6 data low address");
    do_read(11'h7FF, 8'hA5, "R6 data top address");
    do_write(11'h055, 8'hC3, 1'b0);
    do_read(11'h055, 8'hC3, "R7 read right after write");
    do_reject(1'b1, 11'h123, 8'hFF);
    do_read(11'h123, 8'h3C, "R8 memory unchanged");
    do_reject(1'b0, 11'h000, 8'h00);
    do_write(11'h200, 8'h96, 1'b1);
    do_read(11'h200, 8'h96, "R9 data stored");
    chk(clash == 0, "R7 bus clash count", clash, 0);
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule